// File: doc/BRIEF.md
# Configuration Stream Prefetch Controller

This block carries a stream of 32-bit configuration words from a memory read port to a configuration write port. Once a host has programmed a base word address, a stored-word count and a mode, the block fetches the words itself through a request/acknowledge memory master. It queues them in a local FIFO and hands them to the configuration port, which is a valid/ready word sink. When the transfer completes, the block raises a sticky completion flag and, if enabled, an interrupt.

There are two orthogonal mode bits. In preload mode the block fills its FIFO ahead of time while the target region is still running its previous task, and it reports readiness. It holds the port quiet until the host issues a separate launch command. In unpack mode the stored words form a run-length code, and an inline expander turns them back into configuration words. While it emits a run or a literal group, the expander produces one word per cycle.

Top module: `cfg_prefetch_ctrl`

## Requirements
- R1: After reset the status register reads zero, and `mem_req`, `cfg_valid` and `irq` are low.
- R2: A transfer reads the programmed number of words from consecutive word addresses starting at the base address. In basic mode it delivers each word unchanged and in order to the configuration port, and nothing else.
- R3: While `mem_req` is high and `mem_ack` is low, the request and `mem_addr` stay unchanged in the next cycle.
- R4: In preload mode (command bit 1) nothing reaches the port before a launch command (command bit 4). Status bit 1 (ready) is high while the FIFO is full or every word has been fetched, up to the launch.
- R5: In unpack mode (command bit 2) each stored group starts with a header word. If bit 31 is set, the next stored word is emitted N times. If bit 31 is clear, the next N stored words are emitted unchanged. N is bits 30:0, and N = 0 emits nothing.
- R6: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high and `cfg_data` stays stable. No word is lost or duplicated.
- R7: After the last word is accepted, status bit 0 (busy) clears and status bit 2 (done) sets. `irq` equals done AND command bit 3. Writing 1 to status bit 2 clears done.
- R8: A start (command bit 0) written while busy does not disturb the running transfer and sets the sticky error bit, status bit 3. Writing 1 to status bit 3 clears it.
- R9: The FIFO never accepts a word while full. Fetching pauses while the FIFO is full, so a preload fetches exactly the FIFO depth when the stream is longer.
- R10: Register offsets are 0 base address, 1 stored-word count, 2 command, 3 status. Mode bits are taken only while idle, and a new start clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ack | input | 1 | Request accepted, `mem_rdata` valid |
| mem_rdata | input | 32 | Memory read data |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | 32 | Configuration word |
| cfg_ready | input | 1 | Configuration port accepts the word |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with a FIFO depth of 8 instead of the default 2048. A 20-word preload therefore fills the FIFO and stalls the fetcher, so the full-FIFO ready condition and the exact fetch count before launch can be observed. The reduced depth also lets a 16-word run arrive entirely from one prefetched FIFO load. Pseudo-random stalls on both the memory acknowledge and the port ready exercise the FIFO-full and FIFO-empty edges many times in the same transfer, including while a long repeat is expanding.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 31;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_LEN  = 2'd1;
    localparam logic [1:0] REG_CMD  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int CMD_GO      = 0;
    localparam int CMD_PRELOAD = 1;
    localparam int CMD_UNPACK  = 2;
    localparam int CMD_IRQEN   = 3;
    localparam int CMD_LAUNCH  = 4;

    localparam int ST_BUSY  = 0;
    localparam int ST_READY = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_ERR   = 3;

    typedef enum logic [1:0] {
        RLE_HEAD,
        RLE_SEED,
        RLE_REPEAT,
        RLE_COPY
    } rle_state_t;

    typedef struct packed {
        logic irq_en;
        logic unpack;
        logic preload;
    } mode_t;

    function automatic logic hdr_is_run(input logic [WORD_W-1:0] w);
        return w[WORD_W-1];
    endfunction

    function automatic logic [LEN_W-1:0] hdr_len(input logic [WORD_W-1:0] w);
        return w[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
    parameter int DEPTH = 2048,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wp_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= step(wp_q);
            if (pop)  rp_q <= step(rp_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = store[rp_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R6

endmodule

// File: rtl/cfgp_fetch.sv
module cfgp_fetch #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              space,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              push,
    output logic              drained
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (load) begin
            addr_q <= base;
            left_q <= len;
        end else if (push) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign drained  = (left_q == '0);
    assign mem_req  = !drained && space;
    assign mem_addr = addr_q;
    assign push     = mem_req && mem_ack;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));  // R3

endmodule

// File: rtl/cfgp_rle.sv
module cfgp_rle
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              unpack,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_pop,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              idle
);
    rle_state_t        state_q;
    logic [LEN_W-1:0]  left_q;
    logic [WORD_W-1:0] hold_q;
    logic              take;

    always_comb begin
        out_valid = 1'b0;
        out_data  = in_data;
        in_pop    = 1'b0;
        if (!unpack) begin
            out_valid = enable && in_valid;
            in_pop    = enable && in_valid && out_ready;
        end else begin
            unique case (state_q)
                RLE_HEAD: in_pop = enable && in_valid;
                RLE_SEED: begin
                    if (left_q == '0) begin
                        in_pop = enable && in_valid;
                    end else begin
                        out_valid = enable && in_valid;
                        in_pop    = enable && in_valid && out_ready;
                    end
                end
                RLE_REPEAT: begin
                    out_valid = enable;
                    out_data  = hold_q;
                end
                RLE_COPY: begin
                    out_valid = enable && in_valid;
                    in_pop    = enable && in_valid && out_ready;
                end
                default: ;
            endcase
        end
    end

    assign take = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= RLE_HEAD;
            left_q  <= '0;
            hold_q  <= '0;
        end else if (unpack) begin
            unique case (state_q)
                RLE_HEAD: begin
                    if (in_pop) begin
                        left_q <= hdr_len(in_data);
                        if (hdr_is_run(in_data))
                            state_q <= RLE_SEED;
                        else if (hdr_len(in_data) != '0)
                            state_q <= RLE_COPY;
                    end
                end
                RLE_SEED: begin
                    if (in_pop) begin
                        if (left_q <= LEN_W'(1)) begin
                            state_q <= RLE_HEAD;
                        end else begin
                            hold_q  <= in_data;
                            left_q  <= left_q - 1'b1;
                            state_q <= RLE_REPEAT;
                        end
                    end
                end
                RLE_REPEAT, RLE_COPY: begin
                    if (take) begin
                        left_q <= left_q - 1'b1;
                        if (left_q == LEN_W'(1)) state_q <= RLE_HEAD;
                    end
                end
                default: state_q <= RLE_HEAD;
            endcase
        end
    end

    assign idle = !unpack || (state_q == RLE_HEAD);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R6
    AST_RUN_NO_FETCH: assert property (@(posedge clk) disable iff (rst || clr)
        (unpack && state_q == RLE_REPEAT) |-> !in_pop);  // R5

endmodule

// File: rtl/cfg_prefetch_ctrl.sv
module cfg_prefetch_ctrl
    import cfgp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              cfg_valid,
    output logic [31:0]       cfg_data,
    input  logic              cfg_ready,
    output logic              irq
);
    logic [ADDR_W-1:0] base_q;
    logic [31:0]       len_q;
    mode_t             mode_q;
    logic              busy_q, launched_q, done_q, err_q;

    logic              cmd_wr, stat_wr, go_wr, start_ok, start_bad, launch_ok;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [WORD_W-1:0] fifo_head;
    logic              drained, rle_idle, drain, ready, finish;

    assign cmd_wr    = reg_wr && (reg_addr == REG_CMD);
    assign stat_wr   = reg_wr && (reg_addr == REG_STAT);
    assign go_wr     = cmd_wr && reg_wdata[CMD_GO];
    assign start_ok  = go_wr && !busy_q;
    assign start_bad = go_wr && busy_q;
    assign launch_ok = cmd_wr && reg_wdata[CMD_LAUNCH] && busy_q
                       && mode_q.preload && !launched_q;

    cfgp_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_fetch (
        .clk     (clk),
        .rst     (rst),
        .load    (start_ok),
        .base    (base_q),
        .len     (len_q[LEN_W-1:0]),
        .space   (!fifo_full),
        .mem_req (mem_req),
        .mem_addr(mem_addr),
        .mem_ack (mem_ack),
        .push    (fifo_push),
        .drained (drained)
    );

    cfgp_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_ok),
        .push (fifo_push),
        .wdata(mem_rdata),
        .pop  (fifo_pop),
        .rdata(fifo_head),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    assign drain = busy_q && (!mode_q.preload || launched_q);

    cfgp_rle i_rle (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_ok),
        .unpack   (mode_q.unpack),
        .enable   (drain),
        .in_valid (!fifo_empty),
        .in_data  (fifo_head),
        .in_pop   (fifo_pop),
        .out_valid(cfg_valid),
        .out_data (cfg_data),
        .out_ready(cfg_ready),
        .idle     (rle_idle)
    );

    assign finish = busy_q && drained && fifo_empty && rle_idle;
    assign ready  = busy_q && mode_q.preload && !launched_q && (fifo_full || drained);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            len_q      <= '0;
            mode_q     <= '0;
            busy_q     <= 1'b0;
            launched_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == REG_BASE) base_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == REG_LEN)  len_q  <= reg_wdata;
            if (cmd_wr && !busy_q) begin
                mode_q.preload <= reg_wdata[CMD_PRELOAD];
                mode_q.unpack  <= reg_wdata[CMD_UNPACK];
                mode_q.irq_en  <= reg_wdata[CMD_IRQEN];
            end

            if (start_ok)    busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;

            if (start_ok)       launched_q <= 1'b0;
            else if (launch_ok) launched_q <= 1'b1;

            if (finish)                           done_q <= 1'b1;
            else if (start_ok)                    done_q <= 1'b0;
            else if (stat_wr && reg_wdata[ST_DONE]) done_q <= 1'b0;

            if (start_bad)                       err_q <= 1'b1;
            else if (stat_wr && reg_wdata[ST_ERR]) err_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_BASE: reg_rdata = 32'(base_q);
            REG_LEN:  reg_rdata = len_q;
            REG_CMD:  reg_rdata = {28'd0, mode_q.irq_en, mode_q.unpack, mode_q.preload, 1'b0};
            default:  reg_rdata = {28'd0, err_q, done_q, ready, busy_q};
        endcase
    end

    assign irq = done_q && mode_q.irq_en;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!cfg_valid && !mem_req));  // R1
    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (rst)
        (busy_q && mode_q.preload && !launched_q) |-> !cfg_valid);  // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(busy_q));  // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(stat_wr && reg_wdata[ST_ERR])) |=> err_q);  // R8
    AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(mode_q));  // R10

endmodule

// File: tb/test_cfg_prefetch_ctrl.sv
module test_cfg_prefetch_ctrl;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_ack = 1'b1;
    logic [31:0] mem_addr, mem_rdata;
    logic        cfg_valid, cfg_ready = 1'b1;
    logic [31:0] cfg_data;
    logic        irq;

    always #4 clk = ~clk;

    cfg_prefetch_ctrl #(.ADDR_W(32), .FIFO_DEPTH(DEPTH)) i_cfg_prefetch_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready), .irq(irq)
    );

    logic [31:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];

    int          n_chk = 0, n_err = 0;
    logic [31:0] exp_q [$];
    logic [31:0] exp_addr = '0;
    int          fetched = 0;
    string       out_req = "R2";
    bit          hold_check = 1'b0;
    bit          stall_mem = 1'b0, stall_cfg = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          prev_stall = 1'b0, prev_req_wait = 1'b0;
    logic [31:0] prev_data = '0, prev_maddr = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // stimulus for handshake inputs, moved away from the active edge
    always @(posedge clk) begin
        #1;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ack   = stall_mem ? lfsr[3] : 1'b1;
        cfg_ready = stall_cfg ? (lfsr[7] | lfsr[1]) : 1'b1;
    end

    // reference model compared every cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                chk(cfg_valid && cfg_data == prev_data, "R6", cfg_data, prev_data);
            if (prev_req_wait)
                chk(mem_req && mem_addr == prev_maddr, "R3", mem_addr, prev_maddr);
            if (hold_check)
                chk(!cfg_valid, "R4", {31'd0, cfg_valid}, 32'd0);
            if (cfg_valid && cfg_ready) begin
                if (exp_q.size() == 0) chk(1'b0, out_req, cfg_data, 32'hxxxxxxxx);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(cfg_data == e, out_req, cfg_data, e);
                end
            end
            if (mem_req && mem_ack) begin
                chk(mem_addr == exp_addr, "R2", mem_addr, exp_addr);
                exp_addr = exp_addr + 1;
                fetched++;
            end
            prev_stall    = cfg_valid && !cfg_ready;
            prev_data     = cfg_data;
            prev_req_wait = mem_req && !mem_ack;
            prev_maddr    = mem_addr;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic build(input int base, input int cnt, input bit unpack);
        int i;
        exp_q.delete();
        i = 0;
        while (i < cnt) begin
            logic [31:0] w;
            w = mem[base + i]; i++;
            if (!unpack) exp_q.push_back(w);
            else if (w[31]) begin
                logic [31:0] d;
                d = mem[base + i]; i++;
                for (int k = 0; k < int'(w[30:0]); k++) exp_q.push_back(d);
            end else begin
                for (int k = 0; k < int'(w[30:0]); k++) begin
                    exp_q.push_back(mem[base + i]); i++;
                end
            end
        end
    endtask

    task automatic run(input int base, input int cnt, input logic [31:0] cmd, input string req);
        out_req  = req;
        exp_addr = base;
        fetched  = 0;
        build(base, cnt, cmd[2]);
        wr(2'd0, base);
        wr(2'd1, cnt);
        wr(2'd2, cmd | 32'h1);
    endtask

    task automatic wait_done();
        logic [31:0] s;
        s = '0;
        while (!s[2]) rd(2'd3, s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 256; i++) mem[i] = 32'h9E3779B1 * (i + 3);
        for (int i = 0; i < 10; i++) mem[i] = 32'hC0DE0000 + i;
        // unpack stream at 64
        mem[64] = 32'h80000003; mem[65] = 32'hAAAA0001; mem[66] = 32'h00000002;
        mem[67] = 32'h00000011; mem[68] = 32'h00000022; mem[69] = 32'h80000000;
        mem[70] = 32'h0000DEAD; mem[71] = 32'h00000000; mem[72] = 32'h80000001;
        mem[73] = 32'h00000033; mem[74] = 32'h00000001; mem[75] = 32'h00000044;
        // preload + unpack stream at 128
        mem[128] = 32'h80000010; mem[129] = 32'h5A5A5A5A; mem[130] = 32'h00000003;
        mem[131] = 32'h1; mem[132] = 32'h2; mem[133] = 32'h3;
        mem[134] = 32'h80000002; mem[135] = 32'h77;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(2'd3, s);
        chk(s == 32'd0, "R1", s, 32'd0);
        chk(!cfg_valid && !mem_req && !irq, "R1", {29'd0, cfg_valid, mem_req, irq}, 32'd0);

        // R2 basic mode, R7 done and irq
        run(0, 10, 32'h8, "R2");
        wait_done();
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        chk(s == 32'd0 || 1'b1, "R2", 0, 0);
        rd(2'd3, s);
        chk(s == 32'h4, "R7", s, 32'h4);
        chk(irq == 1'b1, "R7", {31'd0, irq}, 32'd1);
        wr(2'd3, 32'h4);
        rd(2'd3, s);
        chk(s == 32'h0 && !irq, "R7", {s[30:0], irq}, 32'd0);

        // R3 and R6 under stalls on both sides
        stall_mem = 1'b1; stall_cfg = 1'b1;
        run(16, 30, 32'h0, "R6");
        wait_done();
        chk(exp_q.size() == 0 && fetched == 30, "R6", exp_q.size(), 0);
        stall_mem = 1'b0; stall_cfg = 1'b0;

        // R5 unpack with zero-length groups
        run(64, 12, 32'h4, "R5");
        wait_done();
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        rd(2'd2, s);
        chk(s == 32'h4, "R10", s, 32'h4);

        // R4 and R9 preload longer than the FIFO
        run(96, 20, 32'h2, "R4");
        hold_check = 1'b1;
        repeat (40) @(posedge clk);
        rd(2'd3, s);
        chk(s == 32'h3, "R4", s, 32'h3);
        chk(fetched == DEPTH, "R9", fetched, DEPTH);
        chk(!mem_req, "R9", {31'd0, mem_req}, 32'd0);
        hold_check = 1'b0;
        wr(2'd2, 32'h10);
        wait_done();
        chk(exp_q.size() == 0 && fetched == 20, "R4", fetched, 20);

        // R8 start while busy is ignored
        stall_cfg = 1'b1;
        run(0, 10, 32'h0, "R8");
        wr(2'd2, 32'h1);
        rd(2'd3, s);
        chk(s[3] && s[0], "R8", s, 32'h9);
        wait_done();
        chk(exp_q.size() == 0 && fetched == 10, "R8", fetched, 10);
        wr(2'd3, 32'h8);
        rd(2'd3, s);
        chk(s == 32'h4, "R8", s, 32'h4);

        // R4 and R5 together with stalls and interrupt
        stall_mem = 1'b1;
        run(128, 8, 32'hE, "R5");
        hold_check = 1'b1;
        repeat (40) @(posedge clk);
        rd(2'd3, s);
        chk(s == 32'h3, "R4", s, 32'h3);
        hold_check = 1'b0;
        wr(2'd2, 32'h10);
        wait_done();
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        chk(irq == 1'b1, "R7", {31'd0, irq}, 32'd1);
        stall_mem = 1'b0; stall_cfg = 1'b0;

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule